// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills every word of a time-slot switch's connection memory in one hardware sweep. Each word gets a 4-bit control pattern in its top nibble and zeros in its lower twelve bits. Software uses it to put all output channels into a known per-channel mode without writing each word itself. The block owns a 16-bit control word that holds a fill enable, the pattern and a begin flag. It also takes a frame-start strobe from the timing unit and shares the memory's single write port with ordinary processor writes.

A fill is requested by one control write that sets the enable, the pattern and the begin flag together while begin was previously clear. The sweep waits for the next frame strobe. It then writes one word on every second cycle, which leaves the other cycles free for the per-slot reads of the switching path. When the last word is written, hardware clears the begin flag. Software can stop a fill early by clearing begin or enable. While a fill is pending or running, processor writes to the memory are held off with a stall signal.

Top module: `cm_block_fill`

## Requirements
- R1: After reset the control word reads 0x0000. A control write stores bits 9..0 as written, and bits 15..10 always read as zero.
- R2: A fill is requested only by a control write with bit 9 (enable) = 1 and bit 4 (begin) = 1 while the stored begin bit is 0. A write that sets begin with enable = 0 leaves the memory unchanged.
- R3: The sweep starts at the first frame strobe sampled after the requesting write. It ignores strobes that come earlier. Word k is written on the clock edge 2+2k cycles after the edge that samples the strobe.
- R4: Every word written by a fill holds bits 8..5 of the control word (the pattern) in bits 15..12 and zeros in bits 11..0.
- R5: A fill is finished no later than the second frame strobe after its request, provided frames are at least twice the memory depth in cycles. The busy output falls on the edge that writes the last word.
- R6: On completion the stored begin bit returns to 0, and all other control bits keep their values.
- R7: A control write during a pending or running fill that clears begin or enable aborts it at that edge. Words not yet written keep their previous contents, and busy is low after that edge.
- R8: While busy is high, stall is high and a processor memory write is not applied. Otherwise a processor write is applied on the next edge.
- R9: The read port returns the word at the read address one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 16 | Control word write value |
| ctrl_rd_data | output | 16 | Control word readback |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| cpu_wr_en | input | 1 | Processor memory write request |
| cpu_addr | input | ADDR_W | Processor memory write address |
| cpu_wr_data | input | 16 | Processor memory write data |
| cpu_stall | output | 1 | Processor write held off |
| rd_addr | input | ADDR_W | Slot read address |
| rd_data | output | 16 | Slot read data, one cycle latency |
| fill_busy | output | 1 | Fill pending or in progress |

## Verification
Results are due at fixed offsets from the frame strobe. Busy and stall are visible one cycle after the request edge. Word k changes on edge 2+2k after the strobe edge and shows on the read port one edge later. Busy drops and begin clears on edge 2·depth, and a held processor write lands one edge after that. An abort takes effect on the edge that latches the control write. The bench counts edges from its own strobe task and samples only at falling edges. For each of these results it checks both the last cycle with the old value and the first cycle with the new one, so an off-by-one in the sweep or the abort is caught.

// File: rtl/cm_fill_pkg.sv
// Shared field positions and state encoding for the connection memory
// block initializer. Assumes a 16-bit control word and 16-bit memory words.
package cm_fill_pkg;
    localparam int WORD_W    = 16;
    localparam int CTRL_USED = 10;   // bits 9..0 are stored
    localparam int EN_BIT    = 9;
    localparam int PAT_LSB   = 5;
    localparam int PAT_W     = 4;
    localparam int BEGIN_BIT = 4;
    localparam int ZERO_W    = WORD_W - PAT_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SWEEP = 2'd2
    } fill_state_t;
endpackage

// File: rtl/cm_ctrl_reg.sv
// Control word holder. Stores bits 9..0 on a write and returns zeros above
// them. It raises start_req on a begin 0->1 write with enable set, and
// stop_req on any write that leaves begin or enable clear. Hardware clears
// begin when the sequencer reports completion; a same-cycle write wins.
module cm_ctrl_reg
    import cm_fill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fill_done,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              start_req,
    output logic              stop_req
);
    logic [CTRL_USED-1:0] stored;

    // Decode request and abort conditions from the incoming write
    always_comb begin
        start_req = wr_en && wr_data[EN_BIT] && wr_data[BEGIN_BIT] && !stored[BEGIN_BIT];
        stop_req  = wr_en && !(wr_data[EN_BIT] && wr_data[BEGIN_BIT]);
        ctrl_q    = {{(WORD_W-CTRL_USED){1'b0}}, stored};
    end

    // Register update: software write first, else self-clear of begin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (wr_en) begin
            stored <= wr_data[CTRL_USED-1:0];
        end else if (fill_done) begin
            stored[BEGIN_BIT] <= 1'b0;
        end
    end

    // R6
    begin_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !wr_en) |=> !ctrl_q[BEGIN_BIT]);
endmodule

// File: rtl/cm_fill_seq.sv
// Sweep sequencer. It arms on start_req and begins at the next frame strobe.
// It then writes one address on every second cycle. The caller must keep
// the frame length at or above twice the memory depth.
module cm_fill_seq
    import cm_fill_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              frame_start,
    input  logic [PAT_W-1:0]  pattern,
    output logic              busy,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [WORD_W-1:0] fill_data,
    output logic              fill_done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    fill_state_t state;
    logic        phase;

    // Write slot strobes and the data word presented to memory
    always_comb begin
        busy      = (state != ST_IDLE);
        fill_we   = (state == ST_SWEEP) && phase && !stop_req;
        fill_done = fill_we && (fill_addr == LAST_ADDR);
        fill_data = {pattern, {ZERO_W{1'b0}}};
    end

    // State, address and slot phase progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fill_addr <= '0;
            phase     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (stop_req) begin
                        state <= ST_IDLE;
                    end else if (frame_start) begin
                        state     <= ST_SWEEP;
                        fill_addr <= '0;
                        phase     <= 1'b0;
                    end
                end
                ST_SWEEP: begin
                    if (stop_req) begin
                        state <= ST_IDLE;
                    end else begin
                        phase <= !phase;
                        if (phase) begin
                            fill_addr <= fill_addr + 1'b1;
                            if (fill_addr == LAST_ADDR) state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    sweep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && frame_start && !stop_req) |=>
            (state == ST_SWEEP && fill_addr == '0 && !fill_we));
    // R5
    two_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && frame_start) |-> (fill_done || stop_req));
    // R7
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_req) |=> !busy);
endmodule

// File: rtl/cm_store.sv
// Connection memory model: one write port shared by the sweep and the
// processor (the sweep has priority), and one registered read port. The
// array itself is not reset, as in a real RAM.
module cm_store
    import cm_fill_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Single write port: sweep word, else processor word
    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem[fill_addr] <= fill_data;
        end else if (cpu_we) begin
            mem[cpu_addr] <= cpu_data;
        end
    end

    // Registered slot read
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end

    // R8
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_we && cpu_we));
    // R4
    fill_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (fill_data[ZERO_W-1:0] == '0));
endmodule

// File: rtl/cm_block_fill.sv
// Top of the connection memory block initializer. It joins the control
// word, the sweep sequencer and the memory model, and stalls processor
// writes while a fill is pending or running.
module cm_block_fill
    import cm_fill_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [15:0]       ctrl_wr_data,
    output logic [15:0]       ctrl_rd_data,
    input  logic              frame_start,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wr_data,
    output logic              cpu_stall,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              fill_busy
);
    logic              start_req, stop_req, fill_done, fill_we, cpu_we_ok;
    logic [ADDR_W-1:0] fill_addr;
    logic [WORD_W-1:0] fill_data;

    // Processor write gating against the sweep
    always_comb begin
        cpu_stall = fill_busy;
        cpu_we_ok = cpu_wr_en && !fill_busy;
    end

    cm_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr_en),
        .wr_data   (ctrl_wr_data),
        .fill_done (fill_done),
        .ctrl_q    (ctrl_rd_data),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    cm_fill_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .frame_start (frame_start),
        .pattern     (ctrl_rd_data[PAT_LSB +: PAT_W]),
        .busy        (fill_busy),
        .fill_we     (fill_we),
        .fill_addr   (fill_addr),
        .fill_data   (fill_data),
        .fill_done   (fill_done)
    );

    cm_store #(.ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .cpu_we    (cpu_we_ok),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && cpu_stall) |-> !cpu_we_ok);
endmodule

// File: tb/test_cm_block_fill.sv
module test_cm_block_fill;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr_en = 1'b0;
    logic [15:0]   ctrl_wr_data = '0;
    logic [15:0]   ctrl_rd_data;
    logic          frame_start = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wr_data = '0;
    logic          cpu_stall;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          fill_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cm_block_fill #(.ADDR_W(AW)) i_cm_block_fill (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
        .ctrl_rd_data(ctrl_rd_data), .frame_start(frame_start), .cpu_wr_en(cpu_wr_en),
        .cpu_addr(cpu_addr), .cpu_wr_data(cpu_wr_data), .cpu_stall(cpu_stall),
        .rd_addr(rd_addr), .rd_data(rd_data), .fill_busy(fill_busy)
    );

    function automatic logic [15:0] cword(bit en, logic [3:0] pat, bit beg, logic [3:0] low);
        return (16'(en) << 9) | (16'(pat) << 5) | (16'(beg) << 4) | 16'(low);
    endfunction

    function automatic logic [15:0] pre(int k, int seed);
        return 16'h5A3C ^ 16'(k * 16'h0123 + seed);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_ctrl(logic [15:0] v);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = v;
        @(negedge clk); ctrl_wr_en = 1'b0;
    endtask

    task automatic cpu_write(int a, logic [15:0] d);
        @(negedge clk); cpu_wr_en = 1'b1; cpu_addr = AW'(a); cpu_wr_data = d;
        @(negedge clk); cpu_wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic read_word(int a, output logic [15:0] v);
        @(negedge clk); rd_addr = AW'(a);
        @(negedge clk); v = rd_data;
    endtask

    task automatic preload(int seed);
        for (int k = 0; k < DEPTH; k++) cpu_write(k, pre(k, seed));
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ctrl", ctrl_rd_data, 16'h0000);
        chk("R7 reset busy", {15'b0, fill_busy}, 16'h0);
        chk("R8 reset stall", {15'b0, cpu_stall}, 16'h0);

        // R1 upper bits read zero
        write_ctrl(16'hFC0B);
        chk("R1 readback", ctrl_rd_data, 16'h000B);

        // R9 / R8 processor writes land when idle, read back
        preload(0);
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R9 preload readback", v, pre(k, 0));
        end

        // R2 begin without enable: no fill, memory untouched
        write_ctrl(cword(0, 4'hC, 1, 4'h0));
        chk("R2 no busy", {15'b0, fill_busy}, 16'h0);
        strobe();
        repeat (2 * DEPTH + 4) @(negedge clk);
        strobe();
        repeat (2 * DEPTH + 4) @(negedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R2 memory unchanged", v, pre(k, 0));
        end
        write_ctrl(cword(0, 4'h0, 0, 4'h0));

        // Full fill with pattern 9, a held processor write and low bits 5
        write_ctrl(cword(1, 4'h9, 1, 4'h5));
        chk("R8 stall while armed", {15'b0, cpu_stall}, 16'h1);
        cpu_wr_en = 1'b1; cpu_addr = AW'(3); cpu_wr_data = 16'h1234;
        rd_addr = '0;
        repeat (5) @(negedge clk);
        chk("R3 armed waits for strobe", {15'b0, fill_busy}, 16'h1);
        strobe();
        for (int n = 1; n <= 2 * DEPTH; n++) begin
            @(negedge clk);
            if (n == 1) chk("R8 stall during sweep", {15'b0, cpu_stall}, 16'h1);
            if (n == 2) chk("R3 word0 not yet written", rd_data, pre(0, 0));
            if (n == 3) chk("R3 word0 written at +2", rd_data, 16'h9000);
            if (n == 2 * DEPTH - 1) chk("R5 busy before last", {15'b0, fill_busy}, 16'h1);
            if (n == 2 * DEPTH) begin
                chk("R5 busy low at last write", {15'b0, fill_busy}, 16'h0);
                chk("R6 begin self-cleared", ctrl_rd_data, cword(1, 4'h9, 0, 4'h5));
                chk("R8 stall released", {15'b0, cpu_stall}, 16'h0);
            end
        end
        @(negedge clk);
        cpu_wr_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R4 fill word", v, (k == 3) ? 16'h1234 : 16'h9000);
        end

        // Second fill, different pattern
        write_ctrl(cword(1, 4'h6, 1, 4'h0));
        strobe();
        repeat (2 * DEPTH) @(negedge clk);
        chk("R6 second fill done", ctrl_rd_data, cword(1, 4'h6, 0, 4'h0));
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R4 second pattern", v, 16'h6000);
        end

        // R7 abort by clearing begin after words 0..6
        preload(7);
        write_ctrl(cword(1, 4'hF, 1, 4'h0));
        strobe();
        repeat (13) @(negedge clk);
        write_ctrl(cword(1, 4'hF, 0, 4'h0));
        chk("R7 busy dropped", {15'b0, fill_busy}, 16'h0);
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R7 abort begin", v, (k <= 6) ? 16'hF000 : pre(k, 7));
        end

        // R7 abort by clearing enable after word 0
        preload(11);
        write_ctrl(cword(1, 4'h3, 1, 4'h0));
        strobe();
        repeat (1) @(negedge clk);
        write_ctrl(cword(0, 4'h3, 1, 4'h0));
        chk("R7 busy dropped enable", {15'b0, fill_busy}, 16'h0);
        repeat (2 * DEPTH) @(negedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            read_word(k, v);
            chk("R7 abort enable", v, (k == 0) ? 16'h3000 : pre(k, 11));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule